// File: doc/BRIEF.md
# Masked TDM Slot Serializer

This block moves 8-bit timeslots onto and off a time-division-multiplexed serial line. A fast engine clock runs the logic. The serial bit clock and frame sync are slow inputs that pass through a synchronizer into the engine-clock domain. Each detected rising edge of the bit clock opens a new bit time. A frame sync that is high at that edge marks bit 0 of slot 0. After that, the block counts bits and slots by itself and wraps at the programmed frame length.

Two mask vectors choose which slots the block drives and which it captures. Each has one bit per slot, for up to `NSLOT` slots. For every driven slot, one byte is taken from a transmit source through a valid/ready handshake and shifted out. Every captured slot produces one byte, which is offered to a receive sink through a valid/ready handshake. Engine-clock counts set two points inside each bit time: when the input is sampled, and when the output enable is released after the last bit of a driven run. Bit order is selectable, and two one-cycle event pulses report a transmit underrun and a receive overrun.

Top module: `tdm_slot_serdes`

## Requirements
- R1: After reset `sdo_oe`, `tx_ready`, `rx_valid`, `tx_empty_evt` and `rx_ovf_evt` are all 0.
- R2: A bit time starts on the third engine-clock rising edge after a rising `bclk_in` is presented. Nothing is driven or captured until the first bit time that starts with `fsync_in` high, and that bit time is bit 0 of slot 0. Between bit starts the output enable does not change, except through the release of R8.
- R3: For slot s with `tx_mask[s]`=1, `tx_ready` is high in the cycle before bit 0 of s starts. The byte offered then is shifted out on `sdo`, one bit per bit time, each bit updated at its bit start.
- R4: `lsb_first`=0 sends and receives bit 7 of a byte first. `lsb_first`=1 sends and receives bit 0 first.
- R5: For slot s with `rx_mask[s]`=1, `sdi` is captured on the `samp_pt`-th engine edge after each bit start, with `samp_pt` at least 1. The assembled byte shows on `rx_data` with `rx_valid`=1 after the edge that samples the eighth bit. It is held until `rx_ready` is seen high.
- R6: Slots with `rx_mask[s]`=0 yield no byte at the sink.
- R7: `sdo_oe` is 1 from the start of bit 0 of a driven slot and stays 1 without a gap across consecutive driven slots.
- R8: In the last bit of a driven slot followed by an undriven one, `sdo_oe` falls on the `rel_time`-th engine edge after that bit start, with `rel_time` at least 1. It falls at the next bit start instead if that comes first.
- R9: If `tx_valid` is 0 when a driven slot begins, `tx_empty_evt` pulses for one cycle and the slot is sent as all zeros with `sdo_oe`=1.
- R10: If a byte completes while the previous one is still unaccepted, `rx_ovf_evt` pulses for one cycle and the new byte replaces the old one.
- R11: With `port_en`=0 the block does not drive `sdo_oe` and makes no handshakes or events. It also drops frame alignment and waits for a new frame sync.
- R12: After `frame_slots` slots, the slot count wraps to 0 without a frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Port enable |
| lsb_first | input | 1 | 0: bit 7 first, 1: bit 0 first |
| samp_pt | input | 16 | Engine edges from bit start to the input sample |
| rel_time | input | 16 | Engine edges from bit start to output release |
| frame_slots | input | 10 | Slots per frame |
| tx_mask | input | 512 | Per-slot drive enable, bit s for slot s |
| rx_mask | input | 512 | Per-slot capture enable, bit s for slot s |
| bclk_in | input | 1 | Serial bit clock (asynchronous) |
| fsync_in | input | 1 | Frame sync (asynchronous) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| tx_data | input | 8 | Byte from the transmit source |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Transmit byte taken this cycle |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte pending |
| rx_ready | input | 1 | Sink accepts the byte |
| tx_empty_evt | output | 1 | One-cycle underrun pulse |
| rx_ovf_evt | output | 1 | One-cycle overrun pulse |

## Verification
The bench drives each bit time as ten engine cycles, with the bit clock rising at cycle 0. A bit start therefore lands on the third edge. `tx_ready` is read in cycle 2 and the underrun pulse in cycle 3. `sdo` and the enable are read in cycle 9, by which point any release with `rel_time` up to 6 has already taken place. Received bytes are due on edge 3+`samp_pt` of the eighth bit. A monitor collects them on falling edges, and they are compared at the end of each frame. Settings change only at a bit-clock rise, and release times of 7 to 9 are avoided, so no expected value depends on a release that is still pending across a bit boundary.

// File: rtl/tdm_pkg.sv
// Shared widths, types and the bit-order helper for the TDM slot serializer.
package tdm_pkg;
    localparam int SLOT_BITS = 8;
    localparam int BIT_W     = $clog2(SLOT_BITS);

    typedef logic [SLOT_BITS-1:0] slot_byte_t;
    typedef logic [BIT_W-1:0]     bit_pos_t;

    localparam bit_pos_t LAST_BIT = bit_pos_t'(SLOT_BITS - 1);

    // Byte index carried in wire bit b for the chosen order.
    function automatic bit_pos_t wire_pos(bit_pos_t b, logic lsb);
        return lsb ? b : bit_pos_t'(LAST_BIT - b);
    endfunction
endpackage

// File: rtl/tdm_line_sync.sv
// Brings the bit clock and frame sync into the engine-clock domain.
// Assumes both inputs are slow against clk; STAGES must be at least 2.
// bit_edge is high for one cycle per rising bit-clock edge.
module tdm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic fsync_in,
    output logic bit_edge,
    output logic fs_level
);
    logic [STAGES:0]   bclk_sh;
    logic [STAGES-1:0] fs_sh;

    // Synchronizer chains plus one extra bit-clock stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_sh <= '0;
            fs_sh   <= '0;
        end else begin
            bclk_sh <= {bclk_sh[STAGES-1:0], bclk_in};
            fs_sh   <= {fs_sh[STAGES-2:0], fsync_in};
        end
    end

    assign bit_edge = bclk_sh[STAGES-1] & ~bclk_sh[STAGES];
    assign fs_level = fs_sh[STAGES-1];
endmodule

// File: rtl/tdm_slot_tracker.sv
// Tracks slot, bit and engine cycles within the bit.
// Locks on the first bit start with frame sync high.
// Assumes frame_slots in 1..NSLOT; 0 or larger values act as NSLOT.
// step marks an accepted bit start; nslot/nbit give the position it enters.
module tdm_slot_tracker
    import tdm_pkg::*;
#(
    parameter int NSLOT = 512,
    parameter int CNT_W = 16,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bit_edge,
    input  logic              fs_level,
    input  logic [SLOT_W:0]   frame_slots,
    output logic              step,
    output logic [SLOT_W-1:0] nslot,
    output bit_pos_t          nbit,
    output logic              locked,
    output logic [SLOT_W-1:0] slot_q,
    output bit_pos_t          bit_q,
    output logic [SLOT_W-1:0] next_slot,
    output logic [CNT_W-1:0]  cyc
);
    logic [SLOT_W:0] last_w;

    // Last slot index of the frame, clamped to the mask size.
    always_comb begin
        if (frame_slots == '0 || frame_slots > (SLOT_W+1)'(NSLOT))
            last_w = (SLOT_W+1)'(NSLOT - 1);
        else
            last_w = frame_slots - 1'b1;
    end

    assign next_slot = ({1'b0, slot_q} == last_w) ? '0 : slot_q + 1'b1;
    assign step      = en && bit_edge && (fs_level || locked);

    // Position entered by an accepted bit start.
    always_comb begin
        if (fs_level) begin
            nslot = '0;
            nbit  = '0;
        end else if (bit_q == LAST_BIT) begin
            nslot = next_slot;
            nbit  = '0;
        end else begin
            nslot = slot_q;
            nbit  = bit_q + 1'b1;
        end
    end

    // Position registers and the saturating cycle-in-bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            locked <= 1'b0;
            slot_q <= '0;
            bit_q  <= '0;
            cyc    <= '0;
        end else if (step) begin
            locked <= 1'b1;
            slot_q <= nslot;
            bit_q  <= nbit;
            cyc    <= CNT_W'(1);
        end else if (cyc != '1) begin
            cyc <= cyc + 1'b1;
        end
    end
endmodule

// File: rtl/tdm_tx_path.sv
// Transmit side: takes one byte per driven slot and shifts it out.
// Owns the output enable, including the early release after the last bit.
// Assumes rel_time >= 1; a release time past the bit end gives way to the next bit start.
module tdm_tx_path
    import tdm_pkg::*;
#(
    parameter int NSLOT = 512,
    parameter int CNT_W = 16,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              step,
    input  logic [SLOT_W-1:0] nslot,
    input  bit_pos_t          nbit,
    input  bit_pos_t          bit_q,
    input  logic [SLOT_W-1:0] next_slot,
    input  logic [CNT_W-1:0]  cyc,
    input  logic [CNT_W-1:0]  rel_time,
    input  logic [NSLOT-1:0]  tx_mask,
    input  logic              lsb_first,
    input  slot_byte_t        tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              tx_empty_evt
);
    slot_byte_t hold_q;
    slot_byte_t load_byte;
    logic       drv_new;
    logic       release_now;

    assign drv_new     = tx_mask[nslot];
    assign tx_ready    = step && (nbit == '0) && drv_new;
    assign load_byte   = tx_valid ? tx_data : '0;
    assign release_now = sdo_oe && (bit_q == LAST_BIT) && !tx_mask[next_slot]
                         && (cyc == rel_time);

    // Output bit, enable, held byte and underrun pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            hold_q       <= '0;
            sdo          <= 1'b0;
            sdo_oe       <= 1'b0;
            tx_empty_evt <= 1'b0;
        end else begin
            tx_empty_evt <= 1'b0;
            if (step) begin
                sdo_oe <= drv_new;
                if (!drv_new) begin
                    sdo <= 1'b0;
                end else if (nbit == '0) begin
                    hold_q       <= load_byte;
                    sdo          <= load_byte[wire_pos(nbit, lsb_first)];
                    tx_empty_evt <= !tx_valid;
                end else begin
                    sdo <= hold_q[wire_pos(nbit, lsb_first)];
                end
            end else if (release_now) begin
                sdo_oe <= 1'b0;
            end
        end
    end

    // R11
    oe_off_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sdo_oe);
    // R8
    oe_fall_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdo_oe) |-> $past(step || !en || cyc == rel_time));
    // R9
    empty_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty_evt |-> sdo_oe);
endmodule

// File: rtl/tdm_rx_path.sv
// Receive side: samples captured slots and offers each finished byte to the sink.
// Assumes samp_pt >= 1. A byte that finishes while the last one is still
// unaccepted replaces it and raises the overrun pulse.
module tdm_rx_path
    import tdm_pkg::*;
#(
    parameter int NSLOT = 512,
    parameter int CNT_W = 16,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              locked,
    input  logic [SLOT_W-1:0] slot_q,
    input  bit_pos_t          bit_q,
    input  logic [CNT_W-1:0]  cyc,
    input  logic [CNT_W-1:0]  samp_pt,
    input  logic [NSLOT-1:0]  rx_mask,
    input  logic              lsb_first,
    input  logic              sdi,
    input  logic              rx_ready,
    output slot_byte_t        rx_data,
    output logic              rx_valid,
    output logic              rx_ovf_evt
);
    slot_byte_t sh_q;
    slot_byte_t sh_next;
    logic       samp;
    logic       done;

    assign samp    = en && locked && (cyc == samp_pt) && rx_mask[slot_q];
    assign done    = samp && (bit_q == LAST_BIT);
    assign sh_next = lsb_first ? {sdi, sh_q[SLOT_BITS-1:1]} : {sh_q[SLOT_BITS-2:0], sdi};

    // Shift register, output byte, valid flag and overrun pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sh_q       <= '0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            rx_ovf_evt <= 1'b0;
        end else begin
            rx_ovf_evt <= 1'b0;
            if (samp) sh_q <= sh_next;
            if (done) begin
                rx_data    <= sh_next;
                rx_valid   <= 1'b1;
                rx_ovf_evt <= rx_valid && !rx_ready;
            end else if (rx_ready) begin
                rx_valid <= 1'b0;
            end
        end
    end

    // R10
    ovf_has_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf_evt |-> rx_valid);
    // R5
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rx_valid && !rx_ready && !done) |=> (rx_valid && $stable(rx_data)));
endmodule

// File: rtl/tdm_slot_serdes.sv
// Top of the masked TDM slot serializer. Connects the line synchronizer, the slot
// tracker and the transmit and receive paths. All logic runs on the engine clock.
// Assumes the bit clock is slower than a few engine cycles per phase.
module tdm_slot_serdes
    import tdm_pkg::*;
#(
    parameter int NSLOT = 512,
    parameter int CNT_W = 16,
    parameter int SYNC_STAGES = 2,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              lsb_first,
    input  logic [CNT_W-1:0]  samp_pt,
    input  logic [CNT_W-1:0]  rel_time,
    input  logic [SLOT_W:0]   frame_slots,
    input  logic [NSLOT-1:0]  tx_mask,
    input  logic [NSLOT-1:0]  rx_mask,
    input  logic              bclk_in,
    input  logic              fsync_in,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic [7:0]        tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [7:0]        rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic              tx_empty_evt,
    output logic              rx_ovf_evt
);
    logic              bit_edge, fs_level, step, locked;
    logic [SLOT_W-1:0] nslot, slot_q, next_slot;
    bit_pos_t          nbit, bit_q;
    logic [CNT_W-1:0]  cyc;

    tdm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .fsync_in(fsync_in),
        .bit_edge(bit_edge), .fs_level(fs_level)
    );

    tdm_slot_tracker #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_track (
        .clk(clk), .rst_n(rst_n), .en(port_en), .bit_edge(bit_edge),
        .fs_level(fs_level), .frame_slots(frame_slots), .step(step),
        .nslot(nslot), .nbit(nbit), .locked(locked), .slot_q(slot_q),
        .bit_q(bit_q), .next_slot(next_slot), .cyc(cyc)
    );

    tdm_tx_path #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(port_en), .step(step), .nslot(nslot),
        .nbit(nbit), .bit_q(bit_q), .next_slot(next_slot), .cyc(cyc),
        .rel_time(rel_time), .tx_mask(tx_mask), .lsb_first(lsb_first),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .sdo(sdo), .sdo_oe(sdo_oe), .tx_empty_evt(tx_empty_evt)
    );

    tdm_rx_path #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(port_en), .locked(locked),
        .slot_q(slot_q), .bit_q(bit_q), .cyc(cyc), .samp_pt(samp_pt),
        .rx_mask(rx_mask), .lsb_first(lsb_first), .sdi(sdi),
        .rx_ready(rx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ovf_evt(rx_ovf_evt)
    );

    // R3
    take_then_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> sdo_oe);
endmodule

// File: tb/tdm_slot_serdes_tb.sv
module tdm_slot_serdes_tb;
    localparam int NSLOT = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic port_en = 1'b0, lsb_first = 1'b0;
    logic [15:0] samp_pt = 16'd4, rel_time = 16'd2;
    logic [9:0] frame_slots = 10'd4;
    logic [NSLOT-1:0] tx_mask = '0, rx_mask = '0;
    logic bclk_in = 1'b0, fsync_in = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe, tx_ready, rx_valid, tx_empty_evt, rx_ovf_evt;
    logic [7:0] tx_data = '0, rx_data;
    logic tx_valid = 1'b0, rx_ready = 1'b1;

    int total = 0, bad = 0;
    int rx_n = 0, ovf_n = 0;
    logic [7:0] rxq [64];
    logic [7:0] txb [16];
    logic       txv [16];
    logic [7:0] rxb [16];
    logic       exp_prev = 1'b0;

    always #10 clk = ~clk;

    tdm_slot_serdes u_dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .lsb_first(lsb_first),
        .samp_pt(samp_pt), .rel_time(rel_time), .frame_slots(frame_slots),
        .tx_mask(tx_mask), .rx_mask(rx_mask), .bclk_in(bclk_in),
        .fsync_in(fsync_in), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_empty_evt(tx_empty_evt), .rx_ovf_evt(rx_ovf_evt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Sink monitor and overrun counter
    always @(negedge clk) begin
        if (rx_valid && rx_ready) begin
            if (rx_n < 64) rxq[rx_n] = rx_data;
            rx_n++;
        end
        if (rx_ovf_evt) ovf_n++;
    end

    function automatic logic exp_bit(input logic [7:0] v, input int b, input logic lsb);
        return lsb ? v[b] : v[7-b];
    endfunction

    // One frame of ns slots, ten engine cycles per bit time.
    task automatic run_frame(input int ns, input bit fs, input bit active, input bit rxcmp);
        logic [7:0] expq [16];
        int exp_n = 0;
        rx_n = 0;
        frame_slots = 10'(ns);
        for (int s = 0; s < ns; s++) begin
            if (active && rx_mask[s]) begin
                expq[exp_n] = rxb[s];
                exp_n++;
            end
            for (int b = 0; b < 8; b++) begin
                logic drv, drvn, e_oe;
                logic [7:0] eb;
                drv  = active && tx_mask[s];
                drvn = active && tx_mask[(s+1) % ns];
                eb   = txv[s] ? txb[s] : 8'h00;
                bclk_in  = 1'b1;
                fsync_in = fs && s == 0 && b == 0;
                sdi      = exp_bit(rxb[s], b, lsb_first);
                if (b == 0) begin
                    tx_valid = txv[s];
                    tx_data  = txb[s];
                end
                for (int n = 1; n <= 10; n++) begin
                    @(negedge clk);
                    if (n == 2) begin
                        chk("R2 oe steady before bit start", 32'(sdo_oe), 32'(exp_prev));
                        if (b == 0) chk("R3 tx_ready", 32'(tx_ready), 32'(drv));
                    end
                    if (n == 3) begin
                        chk("R9 empty pulse", 32'(tx_empty_evt), 32'(drv && b == 0 && !txv[s]));
                        if (drv && b == 0) chk("R7 oe from bit 0", 32'(sdo_oe), 32'd1);
                    end
                    if (n == 5) bclk_in = 1'b0;
                    if (n == 9) begin
                        if (!drv) e_oe = 1'b0;
                        else if (b < 7 || drvn) e_oe = 1'b1;
                        else e_oe = (rel_time <= 16'd6) ? 1'b0 : 1'b1;
                        if (drv && b == 7) chk("R8 release", 32'(sdo_oe), 32'(e_oe));
                        else chk("R7 oe level", 32'(sdo_oe), 32'(e_oe));
                        if (drv) chk("R3/R4 sdo bit", 32'(sdo), 32'(exp_bit(eb, b, lsb_first)));
                        exp_prev = e_oe;
                    end
                end
            end
        end
        fsync_in = 1'b0;
        if (rxcmp) begin
            chk("R6 byte count", 32'(rx_n), 32'(exp_n));
            for (int i = 0; i < exp_n && i < rx_n; i++)
                chk("R5/R4 rx byte", 32'(rxq[i]), 32'(expq[i]));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int ovf0;
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) begin
            txb[i] = 8'($urandom);
            rxb[i] = 8'($urandom);
            txv[i] = 1'b1;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 oe", 32'(sdo_oe), 0);
        chk("R1 tx_ready", 32'(tx_ready), 0);
        chk("R1 rx_valid", 32'(rx_valid), 0);
        chk("R1 events", 32'({tx_empty_evt, rx_ovf_evt}), 0);

        // R2: enabled but no frame sync yet, nothing happens
        port_en = 1'b1;
        tx_mask = '1;
        rx_mask = '1;
        run_frame(4, 1'b0, 1'b0, 1'b1);

        // Directed frame, MSB first, early release
        tx_mask = '0; tx_mask[5:0] = 6'b011011;
        rx_mask = '0; rx_mask[5:0] = 6'b100101;
        lsb_first = 1'b0; samp_pt = 16'd4; rel_time = 16'd2;
        run_frame(6, 1'b1, 1'b1, 1'b1);
        // R12: next frame without frame sync wraps by itself
        run_frame(6, 1'b0, 1'b1, 1'b1);

        // LSB first, late release, underrun in slot 3
        lsb_first = 1'b1; samp_pt = 16'd1; rel_time = 16'd200;
        txv[3] = 1'b0;
        run_frame(6, 1'b1, 1'b1, 1'b1);
        txv[3] = 1'b1;

        // R10 overrun: slots 1 and 2 captured with the sink stalled
        tx_mask = '0;
        rx_mask = '0; rx_mask[2:1] = 2'b11;
        rel_time = 16'd3; rx_ready = 1'b0;
        ovf0 = ovf_n;
        run_frame(4, 1'b1, 1'b1, 1'b0);
        chk("R10 overrun pulses", 32'(ovf_n - ovf0), 32'd1);
        chk("R10 pending flag", 32'(rx_valid), 32'd1);
        chk("R10 newest byte kept", 32'(rx_data), 32'(rxb[2]));
        rx_ready = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 accepted byte cleared", 32'(rx_valid), 32'd0);

        // R11 disabled port
        tx_mask = '1; rx_mask = '1;
        port_en = 1'b0;
        exp_prev = 1'b0;
        run_frame(4, 1'b1, 1'b0, 1'b1);
        port_en = 1'b1;
        tx_mask = '0; tx_mask[3:0] = 4'b1001;
        rx_mask = '0; rx_mask[3:0] = 4'b0110;
        run_frame(4, 1'b1, 1'b1, 1'b1);

        // Random frames
        begin
            int ns = 5;
            for (int fr = 0; fr < 10; fr++) begin
                bit fs;
                fs = (fr == 0) || (fr % 3 != 2);
                if (fs) ns = 3 + int'($urandom % 6);
                tx_mask = '0; tx_mask[31:0] = $urandom;
                rx_mask = '0; rx_mask[31:0] = $urandom;
                lsb_first = 1'($urandom);
                samp_pt = 16'(1 + $urandom % 6);
                case ($urandom % 4)
                    0: rel_time = 16'd12;
                    1: rel_time = 16'd300;
                    default: rel_time = 16'(1 + $urandom % 6);
                endcase
                for (int i = 0; i < 16; i++) begin
                    txb[i] = 8'($urandom);
                    rxb[i] = 8'($urandom);
                    txv[i] = ($urandom % 8) != 0;
                end
                run_frame(ns, fs, 1'b1, 1'b1);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule